// File: doc/BRIEF.md
# Level-Triggered DMA Block Sequencer

This block is one DMA channel that turns a low level on an active-low request pin into one block transfer. Software arms the channel with a single write strobe that also carries the source and destination base addresses, the number of read/write pairs per block and the number of blocks to move. From the clock edge after that write, the pin is sampled on every rising edge while the channel is idle and accepting. A low sample is held inside the channel as a pending request, even if the pin returns high. The pending request raises the bus request.

When the bus is granted, the channel activates and clears the pending request. It then runs the block as alternating read and write cycles and ends it with a single dead cycle. Acceptance stays closed from activation until the dead cycle is over. It then reopens, and the sequence repeats until the block count reaches zero, at which point the completion flag rises.

An optional write-buffer mode keeps the bus request asserted between blocks, so the bus is not handed back between consecutive blocks. A disabling write drops the pending request and sampling at once.

Top module: `dma_lvl_seq`

## Requirements
- R1: The pin is first sampled on the rising edge after the one that captures an enabling write. A low level present only during the write cycle itself is not accepted.
- R2: A low sample taken while accepting sets a held request that raises `bus_req`. The held request stays set after the pin returns high, until activation or a write strobe.
- R3: Activation happens only in idle with a held request and `bus_gnt` high. Without a grant, `cyc_state` stays 0 and `bus_req` stays high.
- R4: The first read strobe of a block comes at least 2 cycles after the request is latched. With the grant already high it comes exactly 2 cycles later.
- R5: A block is `blk_size` read/write pairs, starting with a read, followed by exactly one dead cycle. A `blk_size` of 0 counts as 1. `cyc_state` encodes idle or activation as 0, read as 1, write as 2 and dead as 3.
- R6: A low level on the pin from activation until the dead cycle ends is not latched. After such a block, the channel stays idle with `bus_req` low.
- R7: Acceptance reopens after each dead cycle. After `blk_count` blocks, `done` is high and further low levels start no cycle.
- R8: `src_addr` advances by ADDR_STEP (default 2) after each completed read, and `dst_addr` advances by the same step after each completed write. An enabling write reloads both from the base inputs, visible in the next cycle.
- R9: `rd_stb` and `wr_stb` are high only while `bus_gnt` is high. A read or write cycle without grant stalls in its state with the addresses unchanged.
- R10: With `wbuf_en` high, `bus_req` stays high from the first request until the last block ends. With it low, `bus_req` drops for at least one cycle between blocks.
- R11: A write with `en_val` low clears the held request and any write-buffer hold, and returns the sequencer to idle at that edge. In the next cycle, `bus_req`, `rd_stb` and `wr_stb` are low and no further request is accepted.
- R12: An enabling write with `blk_count` of 0 raises `done` in the next cycle, and no transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_n | input | 1 | Active-low level-sensitive transfer request |
| en_wr | input | 1 | One-cycle strobe that writes the enable control |
| en_val | input | 1 | Enable value written by `en_wr` |
| src_base | input | ADDR_W | Source base address, loaded on an enabling write |
| dst_base | input | ADDR_W | Destination base address, loaded on an enabling write |
| blk_size | input | SIZE_W | Read/write pairs per block, sampled at activation |
| blk_count | input | CNT_W | Number of blocks, loaded on an enabling write |
| wbuf_en | input | 1 | Keep the bus between blocks |
| bus_gnt | input | 1 | Bus grant |
| bus_req | output | 1 | Bus request |
| rd_stb | output | 1 | Read cycle strobe |
| wr_stb | output | 1 | Write cycle strobe |
| src_addr | output | ADDR_W | Current source address |
| dst_addr | output | ADDR_W | Current destination address |
| cyc_state | output | 2 | 0 idle/activation, 1 read, 2 write, 3 dead |
| done | output | 1 | All blocks transferred |

## Verification
The hardest situation to reach from the ports is a low level on the pin that falls inside the closed window, between activation and the end of the dead cycle. It must be proven to leave no trace. The bench raises the request once, then waits until it observes the first read strobe and pulses the pin low for a single cycle in the middle of the block. It then watches long enough after the dead cycle to see that no second block starts, and only then supplies a fresh request to finish the count. The stalled-read abort is reached the same way: the grant is withdrawn exactly when a read state first appears, before the disabling write.

// File: rtl/dls_pkg.sv
package dls_pkg;

   typedef enum logic [2:0] {
      ST_IDLE  = 3'd0,
      ST_ACT   = 3'd1,
      ST_READ  = 3'd2,
      ST_WRITE = 3'd3,
      ST_DEAD  = 3'd4
   } seq_state_t;

   localparam logic [1:0] CYC_IDLE  = 2'd0;
   localparam logic [1:0] CYC_READ  = 2'd1;
   localparam logic [1:0] CYC_WRITE = 2'd2;
   localparam logic [1:0] CYC_DEAD  = 2'd3;

   function automatic logic [1:0] cyc_code(input seq_state_t st);
      case (st)
         ST_READ:  cyc_code = CYC_READ;
         ST_WRITE: cyc_code = CYC_WRITE;
         ST_DEAD:  cyc_code = CYC_DEAD;
         default:  cyc_code = CYC_IDLE;
      endcase
   endfunction

endpackage

// File: rtl/dls_req_latch.sv
module dls_req_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic req_n_i,
   input  logic clear_i,
   output logic held_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_o <= 1'b0;
      else if (clear_i)
         held_o <= 1'b0;
      else if (open_i && !req_n_i)
         held_o <= 1'b1;
   end

   // R2: a pending request only ever comes from an accepted low sample
   assert_latch_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(held_o) |-> $past(open_i && !req_n_i));

   // R2: the pending request survives until a clear is applied
   assert_latch_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (held_o && !clear_i) |=> held_o);

endmodule

// File: rtl/dls_down_cnt.sv
module dls_down_cnt #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] load_val_i,
   input  logic         dec_i,
   output logic [W-1:0] cnt_o
);

   localparam logic [W-1:0] ONE = W'(1);

   initial begin
      assert (W >= 1) else $error("dls_down_cnt: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (load_i)
         cnt_o <= load_val_i;
      else if (dec_i)
         cnt_o <= cnt_o - ONE;
   end

   // R7: counters never wrap below zero
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dec_i && !load_i) |-> (cnt_o != '0));

endmodule

// File: rtl/dls_addr_gen.sv
module dls_addr_gen #(
   parameter int ADDR_W = 16,
   parameter int STEP   = 2,
   parameter int NCH    = 2
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         load_i,
   input  logic [NCH-1:0][ADDR_W-1:0]   base_i,
   input  logic [NCH-1:0]               inc_i,
   output logic [NCH-1:0][ADDR_W-1:0]   addr_o
);

   localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

   initial begin
      assert (STEP >= 1) else $error("dls_addr_gen: STEP must be positive");
      assert (NCH >= 1) else $error("dls_addr_gen: NCH must be positive");
   end

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            addr_o[c] <= '0;
         else if (load_i)
            addr_o[c] <= base_i[c];
         else if (inc_i[c])
            addr_o[c] <= addr_o[c] + STEP_V;
      end

      // R8: an address moves only on its own cycle completion or a reload
      assert_addr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
         (!load_i && !inc_i[c]) |=> $stable(addr_o[c]));
   end

endmodule

// File: rtl/dma_lvl_seq.sv
module dma_lvl_seq
   import dls_pkg::*;
#(
   parameter int ADDR_W       = 16,
   parameter int SIZE_W       = 8,
   parameter int CNT_W        = 8,
   parameter int ADDR_STEP    = 2,
   parameter bit WBUF_SUPPORT = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_n,
   input  logic              en_wr,
   input  logic              en_val,
   input  logic [ADDR_W-1:0] src_base,
   input  logic [ADDR_W-1:0] dst_base,
   input  logic [SIZE_W-1:0] blk_size,
   input  logic [CNT_W-1:0]  blk_count,
   input  logic              wbuf_en,
   input  logic              bus_gnt,
   output logic              bus_req,
   output logic              rd_stb,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] src_addr,
   output logic [ADDR_W-1:0] dst_addr,
   output logic [1:0]        cyc_state,
   output logic              done
);

   localparam logic [SIZE_W-1:0] SIZE_ONE = SIZE_W'(1);
   localparam logic [CNT_W-1:0]  CNT_ONE  = CNT_W'(1);

   initial begin
      assert (ADDR_W >= 2) else $error("dma_lvl_seq: ADDR_W too small");
      assert (SIZE_W >= 1) else $error("dma_lvl_seq: SIZE_W too small");
      assert (CNT_W >= 1) else $error("dma_lvl_seq: CNT_W too small");
      assert (ADDR_STEP >= 1) else $error("dma_lvl_seq: ADDR_STEP must be positive");
   end

   seq_state_t        state_q, state_d;
   logic              enabled_q;
   logic              held;
   logic              keep_bus;
   logic              arm, abort;
   logic              act_go, rd_done, wr_done, dead_end;
   logic              open_acc;
   logic              last_pair;
   logic [SIZE_W-1:0] pair_cnt;
   logic [SIZE_W-1:0] pair_load;
   logic [CNT_W-1:0]  blk_left;

   assign arm   = en_wr &&  en_val;
   assign abort = en_wr && !en_val;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         enabled_q <= 1'b0;
      else if (en_wr)
         enabled_q <= en_val;
   end

   assign done     = enabled_q && (blk_left == '0);
   assign open_acc = enabled_q && (state_q == ST_IDLE) && !done && !en_wr;

   dls_req_latch u_latch (
      .clk     (clk),
      .rst_n   (rst_n),
      .open_i  (open_acc),
      .req_n_i (req_n),
      .clear_i (act_go || en_wr),
      .held_o  (held)
   );

   assign act_go    = (state_q == ST_IDLE) && held && bus_gnt && enabled_q && !en_wr;
   assign rd_done   = (state_q == ST_READ)  && bus_gnt;
   assign wr_done   = (state_q == ST_WRITE) && bus_gnt;
   assign dead_end  = (state_q == ST_DEAD);
   assign last_pair = (pair_cnt <= SIZE_ONE);
   assign pair_load = (blk_size == '0) ? SIZE_ONE : blk_size;

   always_comb begin
      state_d = state_q;
      if (en_wr) begin
         state_d = ST_IDLE;
      end else begin
         case (state_q)
            ST_IDLE:  if (act_go) state_d = ST_ACT;
            ST_ACT:   state_d = ST_READ;
            ST_READ:  if (bus_gnt) state_d = ST_WRITE;
            ST_WRITE: if (bus_gnt) state_d = last_pair ? ST_DEAD : ST_READ;
            ST_DEAD:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state_q <= ST_IDLE;
      else
         state_q <= state_d;
   end

   dls_down_cnt #(.W(SIZE_W)) u_pair_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (act_go),
      .load_val_i (pair_load),
      .dec_i      (wr_done && !en_wr),
      .cnt_o      (pair_cnt)
   );

   dls_down_cnt #(.W(CNT_W)) u_blk_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (arm),
      .load_val_i (blk_count),
      .dec_i      (dead_end && !en_wr),
      .cnt_o      (blk_left)
   );

   if (WBUF_SUPPORT) begin : g_wbuf
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            keep_bus <= 1'b0;
         else if (en_wr || act_go)
            keep_bus <= 1'b0;
         else if (dead_end && wbuf_en && (blk_left > CNT_ONE))
            keep_bus <= 1'b1;
      end
   end else begin : g_no_wbuf
      assign keep_bus = 1'b0;
   end

   logic [1:0][ADDR_W-1:0] bases, addrs;
   assign bases[0] = src_base;
   assign bases[1] = dst_base;

   dls_addr_gen #(.ADDR_W(ADDR_W), .STEP(ADDR_STEP), .NCH(2)) u_addr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (arm),
      .base_i (bases),
      .inc_i  ({wr_done, rd_done}),
      .addr_o (addrs)
   );

   assign src_addr  = addrs[0];
   assign dst_addr  = addrs[1];
   assign rd_stb    = rd_done;
   assign wr_stb    = wr_done;
   assign bus_req   = held || keep_bus || (state_q != ST_IDLE);
   assign cyc_state = cyc_code(state_q);

   // R3: activation follows a pending request seen together with a grant
   assert_act_needs_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_ACT) |-> ($past(held) && $past(bus_gnt)));

   // R4: a read is entered only from activation or a completed write
   assert_read_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && $past(state_q) != ST_READ)
         |-> ($past(state_q) == ST_ACT || $past(state_q) == ST_WRITE));

   // R5: the dead cycle lasts exactly one clock
   assert_dead_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DEAD) |=> (state_q == ST_IDLE));

   // R6: no request is pending while the sequencer is busy
   assert_closed_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) |-> !held);

   // R7: a finished channel starts no bus cycle
   assert_done_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!rd_stb && !wr_stb && state_q == ST_IDLE));

   // R9: a cycle without grant stays where it is
   assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_READ && !bus_gnt && !en_wr) |=> (state_q == ST_READ));

   // R11: a disabling write leaves the channel idle and quiet
   assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $past(abort) |-> (state_q == ST_IDLE && !held && !bus_req));

endmodule

// File: tb/dma_lvl_seq_bench.sv
module dma_lvl_seq_bench;

   localparam int AW   = 16;
   localparam int STEP = 2;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_n;
   logic          en_wr;
   logic          en_val;
   logic [AW-1:0] src_base;
   logic [AW-1:0] dst_base;
   logic [7:0]    blk_size;
   logic [7:0]    blk_count;
   logic          wbuf_en;
   logic          bus_gnt;
   logic          bus_req;
   logic          rd_stb;
   logic          wr_stb;
   logic [AW-1:0] src_addr;
   logic [AW-1:0] dst_addr;
   logic [1:0]    cyc_state;
   logic          done;

   int n_tests = 0;
   int n_fail  = 0;

   always #5 clk = ~clk;

   dma_lvl_seq u_dma_lvl_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_n     (req_n),
      .en_wr     (en_wr),
      .en_val    (en_val),
      .src_base  (src_base),
      .dst_base  (dst_base),
      .blk_size  (blk_size),
      .blk_count (blk_count),
      .wbuf_en   (wbuf_en),
      .bus_gnt   (bus_gnt),
      .bus_req   (bus_req),
      .rd_stb    (rd_stb),
      .wr_stb    (wr_stb),
      .src_addr  (src_addr),
      .dst_addr  (dst_addr),
      .cyc_state (cyc_state),
      .done      (done)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0; req_n = 1'b1; en_wr = 1'b0; en_val = 1'b0;
      src_base = '0; dst_base = '0; blk_size = 8'd1; blk_count = 8'd1;
      wbuf_en = 1'b0; bus_gnt = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   // Write the enable control; returns on the negedge after the write edge.
   task automatic cfg(input bit val, input int sb, input int db, input int sz, input int cnt);
      @(negedge clk);
      en_wr = 1'b1; en_val = val;
      src_base = AW'(sb); dst_base = AW'(db);
      blk_size = 8'(sz); blk_count = 8'(cnt);
      @(negedge clk);
      en_wr = 1'b0;
   endtask

   // Observe until done or limit: counts strobes, dead cycles, bus release gaps.
   task automatic monitor(input int limit, output int nrd, output int nwr, output int ndead,
                          output int gaps, output int seqerr, output int lat);
      int last = 0;
      int first_req = -1;
      int first_rd = -1;
      nrd = 0; nwr = 0; ndead = 0; gaps = 0; seqerr = 0; lat = -1;
      for (int i = 0; i < limit; i++) begin
         if (bus_req && first_req < 0) first_req = i;
         if (rd_stb && first_rd < 0) first_rd = i;
         if (first_req >= 0 && !bus_req && !done) gaps++;
         if (rd_stb) begin
            nrd++;
            if (last == 1) seqerr++;
            last = 1;
         end
         if (wr_stb) begin
            nwr++;
            if (last != 1) seqerr++;
            last = 2;
         end
         if (cyc_state == 2'd3) begin
            ndead++;
            if (last != 2) seqerr++;
            last = 3;
         end
         if (done) break;
         @(negedge clk);
      end
      if (first_req >= 0 && first_rd >= 0) lat = first_rd - first_req;
   endtask

   task automatic t_reset_state();
      apply_reset();
      check(bus_req == 0 && rd_stb == 0 && wr_stb == 0, "reset outputs", int'(bus_req), 0);
      check(cyc_state == 2'd0 && done == 0, "reset state", int'(cyc_state), 0);
   endtask

   task automatic t_first_sample_R1();
      // low only in the write cycle: not accepted
      apply_reset();
      req_n = 1'b0;
      cfg(1'b1, 0, 0, 1, 1);
      req_n = 1'b1;
      repeat (2) @(negedge clk);
      check(bus_req == 1'b0, "R1 low during enable write ignored", int'(bus_req), 0);
      // low held through the next cycle: sampled on the following edge
      apply_reset();
      req_n = 1'b0;
      cfg(1'b1, 0, 0, 1, 1);
      @(negedge clk);
      req_n = 1'b1;
      check(bus_req == 1'b1, "R1 first edge after enable samples", int'(bus_req), 1);
   endtask

   task automatic t_hold_R2_R3();
      apply_reset();
      cfg(1'b1, 0, 0, 1, 1);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      repeat (4) @(negedge clk);
      check(bus_req == 1'b1, "R2 request held after pin release", int'(bus_req), 1);
      check(cyc_state == 2'd0 && !rd_stb, "R3 no activation without grant", int'(cyc_state), 0);
   endtask

   task automatic t_block_R4_R5_R8();
      int nrd, nwr, ndead, gaps, seqerr, lat;
      apply_reset();
      bus_gnt = 1'b1;
      req_n = 1'b0;
      cfg(1'b1, 'h100, 'h2000, 3, 1);
      monitor(100, nrd, nwr, ndead, gaps, seqerr, lat);
      check(lat == 2, "R4 latch to first read", lat, 2);
      check(nrd == 3 && nwr == 3, "R5 pairs per block", nrd, 3);
      check(ndead == 1 && seqerr == 0, "R5 order and single dead", seqerr, 0);
      check(src_addr == AW'('h100 + 3 * STEP), "R8 source address", int'(src_addr), 'h100 + 3 * STEP);
      check(dst_addr == AW'('h2000 + 3 * STEP), "R8 destination address", int'(dst_addr), 'h2000 + 3 * STEP);
      check(done == 1'b1, "R7 done after single block", int'(done), 1);
      cfg(1'b1, 'h40, 'h80, 1, 1);
      check(src_addr == AW'('h40) && dst_addr == AW'('h80), "R8 reload on enable", int'(src_addr), 'h40);
      // size 0 behaves as a single pair
      req_n = 1'b0;
      cfg(1'b1, 0, 0, 0, 1);
      monitor(100, nrd, nwr, ndead, gaps, seqerr, lat);
      check(nrd == 1 && nwr == 1 && ndead == 1, "R5 zero size is one pair", nrd, 1);
      req_n = 1'b1;
   endtask

   task automatic t_closed_R6_R7();
      int seen = 0;
      int nrd, nwr, ndead, gaps, seqerr, lat;
      apply_reset();
      bus_gnt = 1'b1;
      cfg(1'b1, 0, 0, 4, 2);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      for (int i = 0; i < 20 && !rd_stb; i++) @(negedge clk);
      seen = rd_stb ? 1 : 0;
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      for (int i = 0; i < 30; i++) begin
         if (rd_stb) seen++;
         @(negedge clk);
      end
      check(seen == 4, "R6 reads with pulse in closed window", seen, 4);
      check(bus_req == 1'b0 && cyc_state == 2'd0 && done == 1'b0, "R6 no second block",
            int'(bus_req), 0);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      monitor(100, nrd, nwr, ndead, gaps, seqerr, lat);
      check(nrd == 4 && done == 1'b1, "R7 reopened for second block", nrd, 4);
      req_n = 1'b0;
      seen = 0;
      for (int i = 0; i < 8; i++) begin
         @(negedge clk);
         if (rd_stb || wr_stb || bus_req) seen++;
      end
      req_n = 1'b1;
      check(seen == 0, "R7 requests ignored after done", seen, 0);
   endtask

   task automatic t_wbuf_R10();
      int nrd, nwr, ndead, gaps, seqerr, lat;
      apply_reset();
      bus_gnt = 1'b1;
      req_n = 1'b0;
      cfg(1'b1, 0, 0, 2, 3);
      monitor(200, nrd, nwr, ndead, gaps, seqerr, lat);
      check(nrd == 6 && ndead == 3 && done, "R7 three blocks no buffer", nrd, 6);
      check(gaps > 0, "R10 bus released between blocks", gaps, 1);
      apply_reset();
      bus_gnt = 1'b1;
      wbuf_en = 1'b1;
      req_n = 1'b0;
      cfg(1'b1, 0, 0, 2, 3);
      monitor(200, nrd, nwr, ndead, gaps, seqerr, lat);
      check(nrd == 6 && ndead == 3 && done, "R10 three blocks buffered", nrd, 6);
      check(gaps == 0, "R10 bus kept between blocks", gaps, 0);
      req_n = 1'b1;
   endtask

   task automatic t_stall_abort_R9_R11();
      int hold_src;
      int bad = 0;
      apply_reset();
      cfg(1'b1, 'h10, 'h20, 2, 1);
      req_n = 1'b0;
      @(negedge clk);
      req_n = 1'b1;
      bus_gnt = 1'b1;
      for (int i = 0; i < 10 && cyc_state != 2'd1; i++) @(negedge clk);
      bus_gnt = 1'b0;
      hold_src = int'(src_addr);
      repeat (3) @(negedge clk);
      check(cyc_state == 2'd1 && rd_stb == 1'b0, "R9 read stalls without grant", int'(cyc_state), 1);
      check(int'(src_addr) == hold_src, "R9 address frozen in stall", int'(src_addr), hold_src);
      cfg(1'b0, 0, 0, 1, 1);
      check(bus_req == 1'b0 && cyc_state == 2'd0 && !rd_stb && !wr_stb, "R11 abort to idle",
            int'(cyc_state), 0);
      bus_gnt = 1'b1;
      req_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (bus_req || rd_stb || wr_stb) bad++;
      end
      req_n = 1'b1;
      check(bad == 0, "R11 no acceptance after disable", bad, 0);
   endtask

   task automatic t_zero_count_R12();
      int bad = 0;
      apply_reset();
      bus_gnt = 1'b1;
      cfg(1'b1, 0, 0, 2, 0);
      check(done == 1'b1, "R12 done at zero count", int'(done), 1);
      req_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         if (bus_req || rd_stb) bad++;
      end
      req_n = 1'b1;
      check(bad == 0, "R12 no transfer at zero count", bad, 0);
   endtask

   initial begin
      #2_000_000;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset_state();
      t_first_sample_R1();
      t_hold_R2_R3();
      t_block_R4_R5_R8();
      t_closed_R6_R7();
      t_wbuf_R10();
      t_stall_abort_R9_R11();
      t_zero_count_R12();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule